// File: doc/BRIEF.md
# Per-Field Header Rewrite Slice

This block is one lane of the wide action stage that follows a table lookup in a packet pipeline. Each header field has its own copy. The copy keeps the field's current value and a presence flag. On every cycle it may receive one instruction: a 5-bit operation code, a few immediate arguments, and up to three operands that arrive already selected. Each operand has its own valid flag. The first operand comes from the header vector. The second and third come either from the header vector or from the data word that the table lookup returned.

The slice computes a new field value in one clock cycle. The available operations are bitwise logic, shifts, wrapping and saturating arithmetic, unsigned min/max, bit-field deposit, byte-rotate-and-merge, mask-driven bit selection, and three kinds of move. Every operation writes only when the operands it reads are present. When an operation does not write, the field and its presence flag keep their old values. This lets one instruction word serve packets that do or do not carry a given header. The word width `W` is a parameter and may be 8, 16 or 32 bits. Shift amounts, field lengths, offsets, rotate amounts and the byte mask come from the instruction immediates. They never come from the data.

Top module: `fa_slice`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, `fld_data` is 0 and `fld_vld` is 0.
- R2: Logic opcodes are and (1), or (2), xor (3) and not (4). The two-operand forms write `s1 op s2` only when `s1_vld` and `s2_vld` are both set. Not writes `~s1` when `s1_vld` is set.
- R3: Shift opcodes are shift left (5), logical shift right (6) and arithmetic shift right (7). Each shifts `s1` by `ins_amt` and writes only when `s1_vld` is set.
- R4: Add (8) and subtract (9) compute `s1+s2` and `s1-s2` modulo 2^W. Min (12) and max (13) compare `s1` and `s2` unsigned. All four write only when both sources are valid.
- R5: Increment (10) and decrement (11) act on `s1` when `s1_vld` is set. Increment stops at all ones and decrement stops at zero; neither wraps.
- R6: Deposit (14) takes `ins_len` bits of `s1` starting at bit `ins_amt`. It places them at bit `ins_ofs` of `s2` and leaves the other bits of `s2` as they are. A length of W or more moves the whole word. It writes when `s1` and `s2` are valid.
- R7: Rotate-merge (15) rotates `s1` right by `ins_rot1` bytes and `s2` right by `ins_rot2` bytes, so that result byte i is source byte (i+k) mod W/8. It then takes byte i from rotated `s1` where `ins_bmask[i]` is 1 and from rotated `s2` where it is 0. It writes when `s1` and `s2` are valid.
- R8: Bit-select (16) writes `(s2 & s1) | (s3 & ~s1)`, and only when all three sources are valid.
- R9: Move (17) writes `s1` only when `s1_vld` is set.
- R10: Conditional move (18) writes `s1` only when both `s1_vld` and `s2_vld` are set.
- R11: Conditional mux (19) writes `s2` when `s2_vld` is set. Otherwise it writes `s1` when `s1_vld` is set. Otherwise it does not write.
- R12: No-op (0), the unused codes 20 to 31, a low `ins_vld`, and any operation whose validity condition fails all leave `fld_data` and `fld_vld` unchanged.
- R13: A write appears on `fld_data` one clock edge after the instruction is presented, and it sets `fld_vld`. No operation ever clears `fld_vld` outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_vld | input | 1 | An instruction is presented this cycle |
| ins_op | input | 5 | Operation code |
| ins_amt | input | clog2(W) | Shift amount / deposit source offset |
| ins_len | input | clog2(W)+1 | Deposit field length in bits |
| ins_ofs | input | clog2(W) | Deposit destination offset |
| ins_rot1 | input | max(1,clog2(W/8)) | Byte rotate amount for source 1 |
| ins_rot2 | input | max(1,clog2(W/8)) | Byte rotate amount for source 2 |
| ins_bmask | input | W/8 | Byte mask for rotate-merge |
| s1_data | input | W | Source 1 value |
| s1_vld | input | 1 | Source 1 present |
| s2_data | input | W | Source 2 value |
| s2_vld | input | 1 | Source 2 present |
| s3_data | input | W | Source 3 value |
| s3_vld | input | 1 | Source 3 present |
| fld_data | output | W | Current field value |
| fld_vld | output | 1 | Current field present |

## Verification
Two things can decide the same cycle at once. The conditional mux can have both of its candidate sources eligible, and an instruction can be issued while its validity condition fails. The bench presents the mux with both sources valid, then with only the first valid, then with neither. It expects the second source, then the first, then the held value. It also presents a fully valid move while `ins_vld` is low. Saturation is provoked by incrementing an all-ones word and decrementing zero, and each result is judged at the next falling edge.

// File: rtl/fa_pkg.sv
// Shared types for the field action slice: operation codes and result-source select.
package fa_pkg;

    typedef enum logic [4:0] {
        OP_NOP    = 5'd0,
        OP_AND    = 5'd1,
        OP_OR     = 5'd2,
        OP_XOR    = 5'd3,
        OP_NOT    = 5'd4,
        OP_SHL    = 5'd5,
        OP_SHRU   = 5'd6,
        OP_SHRS   = 5'd7,
        OP_ADD    = 5'd8,
        OP_SUB    = 5'd9,
        OP_INC    = 5'd10,
        OP_DEC    = 5'd11,
        OP_MIN    = 5'd12,
        OP_MAX    = 5'd13,
        OP_DEPOS  = 5'd14,
        OP_ROTMRG = 5'd15,
        OP_BITSEL = 5'd16,
        OP_MOVE   = 5'd17,
        OP_CMOVE  = 5'd18,
        OP_CMUX   = 5'd19
    } fa_op_e;

    typedef enum logic [1:0] {
        SEL_ALU  = 2'd0,
        SEL_BYTE = 2'd1,
        SEL_S1   = 2'd2,
        SEL_S2   = 2'd3
    } fa_sel_e;

endpackage

// File: rtl/fa_alu.sv
// Word-level compute for logic, shift, arithmetic and bit-select operations.
// Assumes: purely combinational; the result is ignored unless the gate enables a write.
module fa_alu
    import fa_pkg::*;
#(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  fa_op_e         op,
    input  logic [SW-1:0]  amt,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   c,
    output logic [W-1:0]   res
);

    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    // Select the computed word for the presented operation.
    always_comb begin
        case (op)
            OP_AND:    res = a & b;
            OP_OR:     res = a | b;
            OP_XOR:    res = a ^ b;
            OP_NOT:    res = ~a;
            OP_SHL:    res = a << amt;
            OP_SHRU:   res = a >> amt;
            OP_SHRS:   res = W'($signed(a) >>> amt);
            OP_ADD:    res = a + b;
            OP_SUB:    res = a - b;
            OP_INC:    res = (a == ALL1) ? ALL1 : a + ONE;
            OP_DEC:    res = (a == '0) ? '0 : a - ONE;
            OP_MIN:    res = (a < b) ? a : b;
            OP_MAX:    res = (a > b) ? a : b;
            OP_BITSEL: res = (b & a) | (c & ~a);
            default:   res = '0;
        endcase
    end

endmodule

// File: rtl/fa_bytes.sv
// Bit-field deposit and per-byte rotate-merge datapaths.
// Assumes: W is a multiple of 8; rotate amounts are taken modulo W/8.
module fa_bytes #(
    parameter int W = 32,
    localparam int SW = $clog2(W),
    localparam int NB = W / 8,
    localparam int RW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic           pick_rot,
    input  logic [SW-1:0]  amt,
    input  logic [SW:0]    len,
    input  logic [SW-1:0]  ofs,
    input  logic [RW-1:0]  rot1,
    input  logic [RW-1:0]  rot2,
    input  logic [NB-1:0]  bmask,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);

    logic [W:0]   len_lim;
    logic [W-1:0] fmask;
    logic [W-1:0] fbits;
    logic [W-1:0] dep;
    logic [W-1:0] ra;
    logic [W-1:0] rb;
    logic [W-1:0] mrg;

    // Build the length mask; lengths of W or more give all ones.
    always_comb begin
        len_lim = ({{W{1'b0}}, 1'b1} << len) - 1'b1;
        fmask   = (len >= (SW+1)'(W)) ? '1 : len_lim[W-1:0];
        fbits   = (a >> amt) & fmask;
        dep     = (b & ~(fmask << ofs)) | (fbits << ofs);
    end

    // Rotate each source right by its own byte count.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            ra[8*i +: 8] = a[8*((i + int'(rot1)) % NB) +: 8];
            rb[8*i +: 8] = b[8*((i + int'(rot2)) % NB) +: 8];
        end
    end

    // Per-lane byte choice under the mask.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign mrg[8*g +: 8] = bmask[g] ? ra[8*g +: 8] : rb[8*g +: 8];
    end

    assign res = pick_rot ? mrg : dep;

endmodule

// File: rtl/fa_gate.sv
// Decides, from the operation and the source valid flags, whether the field is written
// and which datapath supplies the new value.
// Assumes: the caller qualifies the write with the instruction strobe.
module fa_gate
    import fa_pkg::*;
(
    input  fa_op_e  op,
    input  logic    v1,
    input  logic    v2,
    input  logic    v3,
    output logic    we,
    output fa_sel_e sel
);

    // Validity rule per operation class.
    always_comb begin
        we  = 1'b0;
        sel = SEL_ALU;
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_ADD, OP_SUB, OP_MIN, OP_MAX: we = v1 & v2;
            OP_NOT, OP_SHL, OP_SHRU, OP_SHRS, OP_INC, OP_DEC:       we = v1;
            OP_BITSEL: we = v1 & v2 & v3;
            OP_DEPOS, OP_ROTMRG: begin
                we  = v1 & v2;
                sel = SEL_BYTE;
            end
            OP_MOVE: begin
                we  = v1;
                sel = SEL_S1;
            end
            OP_CMOVE: begin
                we  = v1 & v2;
                sel = SEL_S1;
            end
            OP_CMUX: begin
                we  = v1 | v2;
                sel = v2 ? SEL_S2 : SEL_S1;
            end
            default: we = 1'b0;
        endcase
    end

endmodule

// File: rtl/fa_slice.sv
// One header-field action slice: holds the field and its presence flag, and applies
// one validity-gated instruction per cycle with the result registered at the next edge.
// Assumes: operands and immediates are already routed; W is 8, 16 or 32.
module fa_slice
    import fa_pkg::*;
#(
    parameter int W = 32,
    localparam int SW = $clog2(W),
    localparam int NB = W / 8,
    localparam int RW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ins_vld,
    input  logic [4:0]     ins_op,
    input  logic [SW-1:0]  ins_amt,
    input  logic [SW:0]    ins_len,
    input  logic [SW-1:0]  ins_ofs,
    input  logic [RW-1:0]  ins_rot1,
    input  logic [RW-1:0]  ins_rot2,
    input  logic [NB-1:0]  ins_bmask,
    input  logic [W-1:0]   s1_data,
    input  logic           s1_vld,
    input  logic [W-1:0]   s2_data,
    input  logic           s2_vld,
    input  logic [W-1:0]   s3_data,
    input  logic           s3_vld,
    output logic [W-1:0]   fld_data,
    output logic           fld_vld
);

    fa_op_e       op;
    logic         gate_we;
    fa_sel_e      sel;
    logic [W-1:0] alu_res;
    logic [W-1:0] byte_res;
    logic [W-1:0] nxt;

    assign op = fa_op_e'(ins_op);

    fa_alu #(.W(W)) u_alu (
        .op  (op),
        .amt (ins_amt),
        .a   (s1_data),
        .b   (s2_data),
        .c   (s3_data),
        .res (alu_res)
    );

    fa_bytes #(.W(W)) u_bytes (
        .pick_rot (op == OP_ROTMRG),
        .amt      (ins_amt),
        .len      (ins_len),
        .ofs      (ins_ofs),
        .rot1     (ins_rot1),
        .rot2     (ins_rot2),
        .bmask    (ins_bmask),
        .a        (s1_data),
        .b        (s2_data),
        .res      (byte_res)
    );

    fa_gate u_gate (
        .op  (op),
        .v1  (s1_vld),
        .v2  (s2_vld),
        .v3  (s3_vld),
        .we  (gate_we),
        .sel (sel)
    );

    // Choose the candidate value for the field.
    always_comb begin
        case (sel)
            SEL_BYTE: nxt = byte_res;
            SEL_S1:   nxt = s1_data;
            SEL_S2:   nxt = s2_data;
            default:  nxt = alu_res;
        endcase
    end

    // Field register: reset to absent, updated only on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_data <= '0;
            fld_vld  <= 1'b0;
        end else if (ins_vld && gate_we) begin
            fld_data <= nxt;
            fld_vld  <= 1'b1;
        end
    end

endmodule

// File: rtl/fa_slice_chk.sv
// Temporal properties of the field action slice, attached to every instance by bind.
// Assumes: the opcode values of fa_pkg.
module fa_slice_chk
    import fa_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ins_vld,
    input logic [4:0]   ins_op,
    input logic [W-1:0] s1_data,
    input logic         s1_vld,
    input logic [W-1:0] s2_data,
    input logic         s2_vld,
    input logic [W-1:0] fld_data,
    input logic         fld_vld
);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_vld |=> ($stable(fld_data) && $stable(fld_vld)));

    p_move_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && ins_op == OP_MOVE && s1_vld) |=> (fld_data == $past(s1_data) && fld_vld));

    p_move_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && ins_op == OP_MOVE && !s1_vld) |=> $stable(fld_data));

    p_cmove_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && ins_op == OP_CMOVE && !s2_vld) |=> $stable(fld_data));

    p_cmux_pri_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && ins_op == OP_CMUX && s2_vld) |=> (fld_data == $past(s2_data)));

    p_inc_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && ins_op == OP_INC && s1_vld && s1_data == '1) |=> (fld_data == '1));

    p_dec_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && ins_op == OP_DEC && s1_vld && s1_data == '0) |=> (fld_data == '0));

    p_vld_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fld_vld |=> fld_vld);

    p_nop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && ins_op == OP_NOP) |=> ($stable(fld_data) && $stable(fld_vld)));

endmodule

bind fa_slice fa_slice_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_vld  (ins_vld),
    .ins_op   (ins_op),
    .s1_data  (s1_data),
    .s1_vld   (s1_vld),
    .s2_data  (s2_data),
    .s2_vld   (s2_vld),
    .fld_data (fld_data),
    .fld_vld  (fld_vld)
);

// File: tb/tb_fa_slice.sv
// Vector-table bench for fa_slice at W=32, followed by directed reset and timing tests.
module tb_fa_slice;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_vld = 1'b0;
    logic [4:0]  ins_op = '0;
    logic [4:0]  ins_amt = '0;
    logic [5:0]  ins_len = '0;
    logic [4:0]  ins_ofs = '0;
    logic [1:0]  ins_rot1 = '0;
    logic [1:0]  ins_rot2 = '0;
    logic [3:0]  ins_bmask = '0;
    logic [31:0] s1_data = '0;
    logic        s1_vld = 1'b0;
    logic [31:0] s2_data = '0;
    logic        s2_vld = 1'b0;
    logic [31:0] s3_data = '0;
    logic        s3_vld = 1'b0;
    logic [31:0] fld_data;
    logic        fld_vld;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    fa_slice #(.W(32)) dut (
        .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_op(ins_op),
        .ins_amt(ins_amt), .ins_len(ins_len), .ins_ofs(ins_ofs),
        .ins_rot1(ins_rot1), .ins_rot2(ins_rot2), .ins_bmask(ins_bmask),
        .s1_data(s1_data), .s1_vld(s1_vld), .s2_data(s2_data), .s2_vld(s2_vld),
        .s3_data(s3_data), .s3_vld(s3_vld), .fld_data(fld_data), .fld_vld(fld_vld)
    );

    typedef struct packed {
        logic [4:0]  op;
        logic [4:0]  amt;
        logic [5:0]  len;
        logic [4:0]  ofs;
        logic [1:0]  r1;
        logic [1:0]  r2;
        logic [3:0]  bm;
        logic [31:0] s1;
        logic        v1;
        logic [31:0] s2;
        logic        v2;
        logic [31:0] s3;
        logic        v3;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t TBL [NV] = '{
        '{5'd17,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h12345678,1'b1,32'h0,1'b0,32'h0,1'b0,32'h12345678,8'd9},   // R9
        '{5'd17,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'hDEADBEEF,1'b0,32'h0,1'b0,32'h0,1'b0,32'h12345678,8'd9},   // R9
        '{5'd1,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'hF0F0F0F0,1'b1,32'hFF00FF00,1'b1,32'h0,1'b0,32'hF000F000,8'd2}, // R2
        '{5'd2,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h0000000F,1'b1,32'h000000F0,1'b0,32'h0,1'b0,32'hF000F000,8'd2}, // R2
        '{5'd2,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h0000000F,1'b1,32'h000000F0,1'b1,32'h0,1'b0,32'h000000FF,8'd2}, // R2
        '{5'd3,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'hAAAA5555,1'b1,32'hFFFF0000,1'b1,32'h0,1'b0,32'h55555555,8'd2}, // R2
        '{5'd4,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h0000FFFF,1'b1,32'h0,1'b0,32'h0,1'b0,32'hFFFF0000,8'd2},      // R2
        '{5'd5,5'd4,6'd0,5'd0,2'd0,2'd0,4'h0,32'h0000ABCD,1'b1,32'h0,1'b0,32'h0,1'b0,32'h000ABCD0,8'd3},      // R3
        '{5'd6,5'd8,6'd0,5'd0,2'd0,2'd0,4'h0,32'h80000000,1'b1,32'h0,1'b0,32'h0,1'b0,32'h00800000,8'd3},      // R3
        '{5'd7,5'd8,6'd0,5'd0,2'd0,2'd0,4'h0,32'h80000000,1'b1,32'h0,1'b0,32'h0,1'b0,32'hFF800000,8'd3},      // R3
        '{5'd8,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'hFFFFFFFF,1'b1,32'h2,1'b1,32'h0,1'b0,32'h00000001,8'd4},      // R4
        '{5'd9,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h5,1'b1,32'h7,1'b1,32'h0,1'b0,32'hFFFFFFFE,8'd4},             // R4
        '{5'd12,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h10,1'b1,32'h20,1'b1,32'h0,1'b0,32'h00000010,8'd4},          // R4
        '{5'd13,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h80000000,1'b1,32'h7FFFFFFF,1'b1,32'h0,1'b0,32'h80000000,8'd4}, // R4
        '{5'd10,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'hFFFFFFFF,1'b1,32'h0,1'b0,32'h0,1'b0,32'hFFFFFFFF,8'd5},     // R5
        '{5'd10,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h40,1'b1,32'h0,1'b0,32'h0,1'b0,32'h00000041,8'd5},           // R5
        '{5'd11,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h0,1'b1,32'h0,1'b0,32'h0,1'b0,32'h00000000,8'd5},            // R5
        '{5'd11,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h100,1'b1,32'h0,1'b0,32'h0,1'b0,32'h000000FF,8'd5},          // R5
        '{5'd14,5'd4,6'd8,5'd12,2'd0,2'd0,4'h0,32'h00000AB0,1'b1,32'h11111111,1'b1,32'h0,1'b0,32'h111AB111,8'd6}, // R6
        '{5'd14,5'd0,6'd32,5'd0,2'd0,2'd0,4'h0,32'hCAFEF00D,1'b1,32'h0,1'b1,32'h0,1'b0,32'hCAFEF00D,8'd6},    // R6
        '{5'd15,5'd0,6'd0,5'd0,2'd1,2'd2,4'h5,32'h44332211,1'b1,32'h88776655,1'b1,32'h0,1'b0,32'h66448822,8'd7}, // R7
        '{5'd16,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'hFFFF0000,1'b1,32'hAAAAAAAA,1'b1,32'h55555555,1'b1,32'hAAAA5555,8'd8}, // R8
        '{5'd16,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h0000FFFF,1'b1,32'h12121212,1'b1,32'h55555555,1'b0,32'hAAAA5555,8'd8}, // R8
        '{5'd18,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h01020304,1'b1,32'h9,1'b0,32'h0,1'b0,32'hAAAA5555,8'd10},    // R10
        '{5'd18,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h01020304,1'b1,32'h9,1'b1,32'h0,1'b0,32'h01020304,8'd10},    // R10
        '{5'd19,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h1111,1'b1,32'h2222,1'b1,32'h0,1'b0,32'h00002222,8'd11},     // R11
        '{5'd19,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h3333,1'b1,32'h4444,1'b0,32'h0,1'b0,32'h00003333,8'd11},     // R11
        '{5'd19,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h5555,1'b0,32'h6666,1'b0,32'h0,1'b0,32'h00003333,8'd11},     // R11
        '{5'd31,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h77777777,1'b1,32'h1,1'b1,32'h1,1'b1,32'h00003333,8'd12},    // R12
        '{5'd0,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h88888888,1'b1,32'h1,1'b1,32'h1,1'b1,32'h00003333,8'd12},     // R12
        '{5'd9,5'd0,6'd0,5'd0,2'd0,2'd0,4'h0,32'h1,1'b0,32'h1,1'b1,32'h0,1'b0,32'h00003333,8'd12}             // R12
    };

    // Compare one observed value pair against its expectation.
    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input logic av, input logic ev);
        checks++;
        if (act !== exp || av !== ev) begin
            failures++;
            $display("FAIL R%0d: data=%h vld=%b expected data=%h vld=%b", req, act, av, exp, ev);
        end
    endtask

    // Present one table vector at a falling edge.
    task automatic drive(input vec_t v);
        ins_vld = 1'b1;   ins_op = v.op;    ins_amt = v.amt;  ins_len = v.len;
        ins_ofs = v.ofs;  ins_rot1 = v.r1;  ins_rot2 = v.r2;  ins_bmask = v.bm;
        s1_data = v.s1;   s1_vld = v.v1;    s2_data = v.s2;   s2_vld = v.v2;
        s3_data = v.s3;   s3_vld = v.v3;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, fld_data, 32'h0, fld_vld, 1'b0);            // R1 during reset
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(posedge clk);
            @(negedge clk);
            check(int'(TBL[i].req), fld_data, TBL[i].exp, fld_vld, 1'b1);
        end

        // R1: reset again and confirm the cleared state
        ins_vld = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(1, fld_data, 32'h0, fld_vld, 1'b0);
        rst_n = 1'b1;

        // R12: failed validity does not set the presence flag
        ins_vld = 1'b1; ins_op = 5'd17; s1_data = 32'h5A5A5A5A; s1_vld = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(12, fld_data, 32'h0, fld_vld, 1'b0);

        // R13: result not visible before the edge, visible after it
        ins_op = 5'd8; s1_data = 32'h3; s1_vld = 1'b1; s2_data = 32'h4; s2_vld = 1'b1;
        #1;
        check(13, fld_data, 32'h0, fld_vld, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check(13, fld_data, 32'h7, fld_vld, 1'b1);

        // R12: valid move ignored while the instruction strobe is low
        ins_vld = 1'b0; ins_op = 5'd17; s1_data = 32'h99; s1_vld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(12, fld_data, 32'h7, fld_vld, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule